// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit virtual address into a translation entry by reading at most two 32-bit descriptors from memory, one at a time. A requester presents the address, the access kind, a context ID and a snapshot of the relevant control state: the split width, both table bases and the access-flag enable. The walker then picks a root table from the top address bits. Before each descriptor read it asks an external address checker whether the read is allowed. It issues single-word reads on a valid/ready port and finishes with either a one-cycle `done` pulse carrying the entry or a one-cycle `fault` pulse carrying a classified fault.

The first-level descriptor either ends the walk as a 1 MB section, points to a second-level table, or faults. The second-level descriptor maps a 64 KB or a 4 KB page, or faults. The entry reports the raw memory-type bits (TEX, C, B, shared) without decoding them. Only one walk runs at a time, and `busy` tells the requester when a new one can start.

Top module: `ptw_engine`

## Requirements
- R1: With split width N (0..7), root table 1 is used and N is treated as 0 when N is nonzero and virtual address bits [31:32-N] are not all zero. Otherwise root table 0 is used with N unchanged. The first read address is root[31:14-N] joined with VA[31-N:20] and two zero bits.
- R2: A first-level descriptor whose type bits [1:0] are 00 or 11, or a section (type 10) with bit 18 set, ends the walk with fault code 3 (level-1 translation) and fault domain 0.
- R3: A section ends the walk with size code 2. In the entry, physical base = {D[31:20], 20 zeros} and VPN = VA>>20. AP = {D[15],D[11:10]}, domain = D[8:5] and global = !D[17]. Shared = D[16], TEX = D[14:12], XN = D[4], C = D[3] and B = D[2]. The context ID is copied from the request.
- R4: Type 01 at level 1 starts a second read at address {D1[31:10], 10 zeros} ORed with VA[19:12] shifted left by 2.
- R5: A second-level descriptor with bits [1:0] = 00 ends the walk with fault code 4 (level-2 translation), and the fault domain is taken from D1[8:5].
- R6: At level 2, type 01 gives a large page and type 1x gives a small page. For a large page: size code 1, base {D[31:16], 16 zeros}, VPN = VA>>16, XN = D[15], TEX = D[14:12]. For a small page: size code 0, base {D[31:12], 12 zeros}, VPN = VA>>12, XN = D[0], TEX = D[8:6]. Both sizes take global = !D[11], shared = D[10], AP = {D[9],D[5:4]}, C = D[3], B = D[2], and the domain from the first level.
- R7: With access-flag enable set, a final descriptor whose AP bit 0 (D[10] for a section, D[4] at level 2) is 0 gives fault code 5 (level 1) or 6 (level 2), with the first-level domain. When that bit is 1 the entry is returned normally.
- R8: Access kind 2 (fetch) reports a prefetch abort (`flt_prefetch`=1, `flt_write`=0). Kinds 0 (read) and 1 (write) report a data abort with `flt_write` = 1 only for kind 1.
- R9: `chk_fault` is sampled in the cycle before each read while `chk_addr` shows that read's address. If it is high, the walk ends with code 1 (before level 1, domain 0) or code 2 (before level 2, first-level domain), and that read is never issued.
- R10: After reset, `busy`, `done`, `fault` and `mem_req_valid` are low. `busy` rises the cycle after an accepted request and falls the cycle after the single-cycle `done` or `fault` pulse. The two pulses never coincide, and `req_valid` while busy is ignored.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request, accepted when busy is low |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_ctx | input | CTX_W | Context ID copied into the entry |
| req_split | input | SPLIT_W | Root split width N |
| req_base0 | input | 32 | Root table 0 base |
| req_base1 | input | 32 | Root table 1 base |
| req_afe | input | 1 | Access-flag fault enable |
| busy | output | 1 | A walk is in progress |
| chk_addr | output | 32 | Address of the next descriptor read, for the checker |
| chk_fault | input | 1 | Checker rejects chk_addr |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle pulse: entry valid |
| ent_pa_base | output | 32 | Physical page base |
| ent_vpn | output | 20 | Virtual page number |
| ent_size | output | 2 | 0 small, 1 large, 2 section |
| ent_ap | output | 3 | Access permissions |
| ent_domain | output | 4 | Domain |
| ent_global | output | 1 | Global mapping |
| ent_xn | output | 1 | Execute never |
| ent_tex | output | 3 | Raw TEX bits |
| ent_c | output | 1 | Raw C bit |
| ent_b | output | 1 | Raw B bit |
| ent_shared | output | 1 | Raw shared bit |
| ent_ctx | output | CTX_W | Context ID of the walk |
| fault | output | 1 | One-cycle pulse: walk faulted |
| flt_code | output | 3 | Fault class, codes as in R2, R5, R7, R9 |
| flt_prefetch | output | 1 | 1 prefetch abort, 0 data abort |
| flt_write | output | 1 | Data abort caused by a write |
| flt_domain | output | 4 | Domain reported with the fault |

## Verification
The bench uses the default parameters: an 8-bit context ID and a 3-bit split width. With these, every split from 0 to the maximum of 7 can be used, so root tables can be selected with no split, with a partial split under either root, and with the narrowest level-1 index. The memory model stalls `mem_req_ready` in a rotating pattern and varies the response latency, so the hold rule and both read phases are exercised under back-pressure. The address checker is aimed at one chosen level-1 or level-2 address so that each early abort can be triggered on its own.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned VA_W   = 32;
    localparam int unsigned DESC_W = 32;
    localparam int unsigned DOM_W  = 4;
    localparam int unsigned VPN_W  = 20;
    localparam int unsigned SEC_SH = 20;
    localparam int unsigned LRG_SH = 16;
    localparam int unsigned SML_SH = 12;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_CHK_L1  = 3'd1,
        FLT_CHK_L2  = 3'd2,
        FLT_XLAT_L1 = 3'd3,
        FLT_XLAT_L2 = 3'd4,
        FLT_AF_L1   = 3'd5,
        FLT_AF_L2   = 3'd6
    } flt_code_e;

    typedef enum logic [1:0] {
        PG_SMALL   = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SECTION = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic [VA_W-1:0]  pa_base;
        logic [VPN_W-1:0] vpn;
        pg_size_e         size;
        logic [2:0]       ap;
        logic [DOM_W-1:0] domain;
        logic             glob;
        logic             xn;
        logic [2:0]       tex;
        logic             cbit;
        logic             bbit;
        logic             shared;
    } xlat_entry_t;

    typedef struct packed {
        flt_code_e        code;
        logic [DOM_W-1:0] domain;
    } flt_t;

    // Page base with the offset bits below 'sh' cleared
    function automatic logic [VA_W-1:0] page_base(input logic [DESC_W-1:0] d, input int unsigned sh);
        return d & ({VA_W{1'b1}} << sh);
    endfunction

    // Virtual page number for a page of 2**sh bytes
    function automatic logic [VPN_W-1:0] page_num(input logic [VA_W-1:0] va, input int unsigned sh);
        logic [VA_W-1:0] t;
        t = va >> sh;
        return t[VPN_W-1:0];
    endfunction

endpackage

// File: rtl/ptw_root_select.sv
module ptw_root_select
    import ptw_pkg::*;
#(
    parameter int unsigned SPLIT_W = 3
) (
    input  logic [VA_W-1:0]    va,
    input  logic [SPLIT_W-1:0] split,
    input  logic [VA_W-1:0]    base0,
    input  logic [VA_W-1:0]    base1,
    output logic [VA_W-1:0]    l1_addr
);
    // Level-1 table covers 4096 entries when N is 0
    localparam int unsigned L1_IDX_W = VA_W - SEC_SH;
    localparam int unsigned L1_TOP   = L1_IDX_W + 2;

    int unsigned     n_eff;
    logic            use_hi;
    logic [VA_W-1:0] top_bits;
    logic [VA_W-1:0] base;
    logic [VA_W-1:0] keep_mask;
    logic [VA_W-1:0] idx_mask;

    always_comb begin
        top_bits  = (split == '0) ? '0 : (va >> (VA_W - int'(split)));
        use_hi    = (split != '0) && (top_bits != '0);
        n_eff     = use_hi ? 0 : int'(split);
        base      = use_hi ? base1 : base0;
        keep_mask = {VA_W{1'b1}} << (L1_TOP - n_eff);
        idx_mask  = (VA_W'(1) << (L1_IDX_W - n_eff)) - VA_W'(1);
        l1_addr   = (base & keep_mask) | (((va >> SEC_SH) & idx_mask) << 2);
    end

endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic              second_level,
    input  logic [DOM_W-1:0]  l1_dom,
    input  logic [VA_W-1:0]   va,
    input  logic              afe,
    output logic              descend,
    output logic [VA_W-1:0]   l2_addr,
    output flt_t              flt,
    output xlat_entry_t       ent
);
    always_comb begin
        descend    = 1'b0;
        l2_addr    = {desc[31:10], 10'b0} | {22'b0, va[19:12], 2'b00};
        flt.code   = FLT_NONE;
        flt.domain = '0;
        ent        = '0;
        if (!second_level) begin
            unique case (desc[1:0])
                2'b01: descend = 1'b1;
                2'b10: begin
                    if (desc[18]) begin
                        flt.code = FLT_XLAT_L1;
                    end else begin
                        ent.pa_base = page_base(desc, SEC_SH);
                        ent.vpn     = page_num(va, SEC_SH);
                        ent.size    = PG_SECTION;
                        ent.ap      = {desc[15], desc[11:10]};
                        ent.domain  = desc[8:5];
                        ent.glob    = ~desc[17];
                        ent.xn      = desc[4];
                        ent.tex     = desc[14:12];
                        ent.cbit    = desc[3];
                        ent.bbit    = desc[2];
                        ent.shared  = desc[16];
                        if (afe && !desc[10]) begin
                            flt.code   = FLT_AF_L1;
                            flt.domain = desc[8:5];
                        end
                    end
                end
                default: flt.code = FLT_XLAT_L1;
            endcase
        end else if (desc[1:0] == 2'b00) begin
            flt.code   = FLT_XLAT_L2;
            flt.domain = l1_dom;
        end else begin
            ent.ap     = {desc[9], desc[5:4]};
            ent.domain = l1_dom;
            ent.glob   = ~desc[11];
            ent.cbit   = desc[3];
            ent.bbit   = desc[2];
            ent.shared = desc[10];
            if (desc[1]) begin
                ent.pa_base = page_base(desc, SML_SH);
                ent.vpn     = page_num(va, SML_SH);
                ent.size    = PG_SMALL;
                ent.xn      = desc[0];
                ent.tex     = desc[8:6];
            end else begin
                ent.pa_base = page_base(desc, LRG_SH);
                ent.vpn     = page_num(va, LRG_SH);
                ent.size    = PG_LARGE;
                ent.xn      = desc[15];
                ent.tex     = desc[14:12];
            end
            if (afe && !desc[4]) begin
                flt.code   = FLT_AF_L2;
                flt.domain = l1_dom;
            end
        end
    end

endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
    import ptw_pkg::*;
#(
    parameter int unsigned CTX_W   = 8,
    parameter int unsigned SPLIT_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [31:0]        req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic [SPLIT_W-1:0] req_split,
    input  logic [31:0]        req_base0,
    input  logic [31:0]        req_base1,
    input  logic               req_afe,
    output logic               busy,
    output logic [31:0]        chk_addr,
    input  logic               chk_fault,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [31:0]        mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               done,
    output logic [31:0]        ent_pa_base,
    output logic [19:0]        ent_vpn,
    output logic [1:0]         ent_size,
    output logic [2:0]         ent_ap,
    output logic [3:0]         ent_domain,
    output logic               ent_global,
    output logic               ent_xn,
    output logic [2:0]         ent_tex,
    output logic               ent_c,
    output logic               ent_b,
    output logic               ent_shared,
    output logic [CTX_W-1:0]   ent_ctx,
    output logic               fault,
    output logic [2:0]         flt_code,
    output logic               flt_prefetch,
    output logic               flt_write,
    output logic [3:0]         flt_domain
);
    typedef enum logic [2:0] {
        S_IDLE, S_CHK1, S_RD1, S_WT1, S_CHK2, S_RD2, S_WT2, S_FIN
    } walk_state_e;

    walk_state_e        st;
    logic [VA_W-1:0]    va_q;
    acc_kind_e          kind_q;
    logic [CTX_W-1:0]   ctx_q;
    logic               afe_q;
    logic [VA_W-1:0]    addr_q;
    logic [DOM_W-1:0]   d1dom_q;
    xlat_entry_t        ent_q;
    flt_t               flt_q;

    logic [VA_W-1:0]    root_addr;
    logic               dec_descend;
    logic [VA_W-1:0]    dec_l2_addr;
    flt_t               dec_flt;
    xlat_entry_t        dec_ent;

    ptw_root_select #(.SPLIT_W(SPLIT_W)) u_root (
        .va      (req_vaddr),
        .split   (req_split),
        .base0   (req_base0),
        .base1   (req_base1),
        .l1_addr (root_addr)
    );

    ptw_desc_decode u_dec (
        .desc         (mem_rsp_data),
        .second_level (st == S_WT2),
        .l1_dom       (d1dom_q),
        .va           (va_q),
        .afe          (afe_q),
        .descend      (dec_descend),
        .l2_addr      (dec_l2_addr),
        .flt          (dec_flt),
        .ent          (dec_ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            va_q    <= '0;
            kind_q  <= ACC_LOAD;
            ctx_q   <= '0;
            afe_q   <= 1'b0;
            addr_q  <= '0;
            d1dom_q <= '0;
            ent_q   <= '0;
            flt_q   <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (req_valid) begin
                    va_q       <= req_vaddr;
                    kind_q     <= acc_kind_e'(req_kind);
                    ctx_q      <= req_ctx;
                    afe_q      <= req_afe;
                    addr_q     <= root_addr;
                    d1dom_q    <= '0;
                    flt_q.code <= FLT_NONE;
                    flt_q.domain <= '0;
                    st         <= S_CHK1;
                end
                S_CHK1: if (chk_fault) begin
                    flt_q.code <= FLT_CHK_L1;
                    flt_q.domain <= '0;
                    st         <= S_FIN;
                end else begin
                    st <= S_RD1;
                end
                S_RD1: if (mem_req_ready) st <= S_WT1;
                S_WT1: if (mem_rsp_valid) begin
                    if (dec_flt.code != FLT_NONE) begin
                        flt_q <= dec_flt;
                        st    <= S_FIN;
                    end else if (dec_descend) begin
                        addr_q  <= dec_l2_addr;
                        d1dom_q <= mem_rsp_data[8:5];
                        st      <= S_CHK2;
                    end else begin
                        ent_q <= dec_ent;
                        st    <= S_FIN;
                    end
                end
                S_CHK2: if (chk_fault) begin
                    flt_q.code <= FLT_CHK_L2;
                    flt_q.domain <= d1dom_q;
                    st         <= S_FIN;
                end else begin
                    st <= S_RD2;
                end
                S_RD2: if (mem_req_ready) st <= S_WT2;
                S_WT2: if (mem_rsp_valid) begin
                    if (dec_flt.code != FLT_NONE) flt_q <= dec_flt;
                    else                          ent_q <= dec_ent;
                    st <= S_FIN;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy          = (st != S_IDLE);
    assign chk_addr      = addr_q;
    assign mem_req_addr  = addr_q;
    assign mem_req_valid = (st == S_RD1) || (st == S_RD2);
    assign done          = (st == S_FIN) && (flt_q.code == FLT_NONE);
    assign fault         = (st == S_FIN) && (flt_q.code != FLT_NONE);

    assign ent_pa_base = ent_q.pa_base;
    assign ent_vpn     = ent_q.vpn;
    assign ent_size    = ent_q.size;
    assign ent_ap      = ent_q.ap;
    assign ent_domain  = ent_q.domain;
    assign ent_global  = ent_q.glob;
    assign ent_xn      = ent_q.xn;
    assign ent_tex     = ent_q.tex;
    assign ent_c       = ent_q.cbit;
    assign ent_b       = ent_q.bbit;
    assign ent_shared  = ent_q.shared;
    assign ent_ctx     = ctx_q;

    assign flt_code     = flt_q.code;
    assign flt_domain   = flt_q.domain;
    assign flt_prefetch = (kind_q == ACC_FETCH);
    assign flt_write    = (kind_q == ACC_STORE);

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);
    // R10
    pulse_release_chk: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |=> (!busy && !done && !fault));
    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, fault}));
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R11
    mem_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);
    // R8
    abort_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && flt_prefetch) |-> !flt_write);
    // R2
    l1_dom_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && (flt_code == 3'd3 || flt_code == 3'd1)) |-> (flt_domain == 4'd0));

endmodule

// File: tb/ptw_engine_test.sv
module ptw_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_ctx = '0;
    logic [2:0]  req_split = '0;
    logic [31:0] req_base0 = 32'h0010_0000;
    logic [31:0] req_base1 = 32'h0020_0000;
    logic        req_afe = 1'b0;
    logic        busy;
    logic [31:0] chk_addr;
    logic        chk_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] ent_pa_base;
    logic [19:0] ent_vpn;
    logic [1:0]  ent_size;
    logic [2:0]  ent_ap;
    logic [3:0]  ent_domain;
    logic        ent_global, ent_xn, ent_c, ent_b, ent_shared;
    logic [2:0]  ent_tex;
    logic [7:0]  ent_ctx;
    logic        fault;
    logic [2:0]  flt_code;
    logic        flt_prefetch, flt_write;
    logic [3:0]  flt_domain;

    always #2.5 clk = ~clk;

    logic        bad_en = 1'b0;
    logic [31:0] bad_addr = '0;
    assign chk_fault = bad_en && (chk_addr == bad_addr);

    ptw_engine uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .req_ctx(req_ctx), .req_split(req_split), .req_base0(req_base0),
        .req_base1(req_base1), .req_afe(req_afe), .busy(busy),
        .chk_addr(chk_addr), .chk_fault(chk_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done),
        .ent_pa_base(ent_pa_base), .ent_vpn(ent_vpn), .ent_size(ent_size),
        .ent_ap(ent_ap), .ent_domain(ent_domain), .ent_global(ent_global),
        .ent_xn(ent_xn), .ent_tex(ent_tex), .ent_c(ent_c), .ent_b(ent_b),
        .ent_shared(ent_shared), .ent_ctx(ent_ctx), .fault(fault),
        .flt_code(flt_code), .flt_prefetch(flt_prefetch), .flt_write(flt_write),
        .flt_domain(flt_domain)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [31:0]];
    int          rd_cnt = 0;
    logic [31:0] rd_addr [2];
    bit          pend = 0;
    int          pcnt = 0;
    logic [31:0] paddr = '0;
    logic [7:0]  rdy_pat = 8'b1011_0110;
    int          lat_sel = 0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        if (prev_stall)
            check(mem_req_valid && (mem_req_addr == prev_addr), "R11", "held request", mem_req_addr, prev_addr);
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (pcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(paddr);
                pend = 0;
            end else pcnt--;
        end
        rdy_pat = {rdy_pat[6:0], rdy_pat[7]};
        mem_req_ready = rdy_pat[0];
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        if (mem_req_valid && mem_req_ready) begin
            if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
            rd_cnt++;
            pend  = 1;
            pcnt  = lat_sel;
            lat_sel = (lat_sel + 1) % 3;
            paddr = mem_req_addr;
        end
    end

    // ---------------- expected model ----------------
    typedef struct {
        bit          is_f;
        logic [2:0]  code;
        logic        pf, wr;
        logic [3:0]  fdom;
        logic [31:0] pa;
        logic [19:0] vpn;
        logic [1:0]  sz;
        logic [2:0]  ap;
        logic [3:0]  dom;
        logic        g, xn, c, b, s;
        logic [2:0]  tex;
        logic [7:0]  ctx;
        int          nreads;
        logic [31:0] a1, a2;
        string       rq;
    } exp_t;

    exp_t sbq[$];

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind,
                                   input logic [7:0] ctx, input logic [2:0] split,
                                   input logic afe, input string rq);
        exp_t e;
        int n;
        logic [31:0] base, d1, d2, tmp;
        e.is_f = 0; e.code = 0; e.fdom = 0; e.pa = 0; e.vpn = 0; e.sz = 0;
        e.ap = 0; e.dom = 0; e.g = 0; e.xn = 0; e.c = 0; e.b = 0; e.s = 0;
        e.tex = 0; e.ctx = ctx; e.nreads = 0; e.a2 = 0; e.rq = rq;
        e.pf = (kind == 2'd2);
        e.wr = (kind == 2'd1);
        n = split;
        if (n != 0 && (va >> (32 - n)) != 0) begin base = req_base1; n = 0; end
        else base = req_base0;
        e.a1 = 0;
        for (int i = 31; i >= 14 - n; i--) e.a1[i] = base[i];
        for (int i = 0; i < 12 - n; i++) e.a1[2 + i] = va[20 + i];
        if (bad_en && e.a1 == bad_addr) begin
            e.is_f = 1; e.code = 3'd1; return e;
        end
        e.nreads = 1;
        d1 = rd(e.a1);
        if (d1[1:0] == 2'b00 || d1[1:0] == 2'b11 || (d1[1:0] == 2'b10 && d1[18])) begin
            e.is_f = 1; e.code = 3'd3; return e;
        end
        if (d1[1:0] == 2'b10) begin
            e.pa = {d1[31:20], 20'h0}; tmp = va >> 20; e.vpn = tmp[19:0]; e.sz = 2'd2;
            e.ap = {d1[15], d1[11:10]}; e.dom = d1[8:5]; e.g = !d1[17];
            e.xn = d1[4]; e.tex = d1[14:12]; e.c = d1[3]; e.b = d1[2]; e.s = d1[16];
            if (afe && !d1[10]) begin e.is_f = 1; e.code = 3'd5; e.fdom = d1[8:5]; end
            return e;
        end
        e.a2 = {d1[31:10], 10'h0} | (32'(va[19:12]) << 2);
        if (bad_en && e.a2 == bad_addr) begin
            e.is_f = 1; e.code = 3'd2; e.fdom = d1[8:5]; return e;
        end
        e.nreads = 2;
        d2 = rd(e.a2);
        if (d2[1:0] == 2'b00) begin
            e.is_f = 1; e.code = 3'd4; e.fdom = d1[8:5]; return e;
        end
        e.ap = {d2[9], d2[5:4]}; e.dom = d1[8:5]; e.g = !d2[11];
        e.c = d2[3]; e.b = d2[2]; e.s = d2[10];
        if (d2[1]) begin
            e.pa = {d2[31:12], 12'h0}; tmp = va >> 12; e.vpn = tmp[19:0]; e.sz = 2'd0;
            e.xn = d2[0]; e.tex = d2[8:6];
        end else begin
            e.pa = {d2[31:16], 16'h0}; tmp = va >> 16; e.vpn = tmp[19:0]; e.sz = 2'd1;
            e.xn = d2[15]; e.tex = d2[14:12];
        end
        if (afe && !d2[4]) begin e.is_f = 1; e.code = 3'd6; e.fdom = d1[8:5]; end
        return e;
    endfunction

    // ---------------- descriptor builders ----------------
    function automatic logic [31:0] mk_sec(input logic [11:0] fr, input logic ng, input logic s,
        input logic [2:0] ap, input logic [2:0] tex, input logic [3:0] dom,
        input logic xn, input logic c, input logic b, input logic ss);
        return {fr, 1'b0, ss, ng, s, ap[2], tex, ap[1:0], 1'b0, dom, xn, c, b, 2'b10};
    endfunction
    function automatic logic [31:0] mk_ptr(input logic [21:0] tb, input logic [3:0] dom);
        return {tb, 1'b0, dom, 3'b000, 2'b01};
    endfunction
    function automatic logic [31:0] mk_small(input logic [19:0] fr, input logic ng, input logic s,
        input logic [2:0] ap, input logic [2:0] tex, input logic c, input logic b, input logic xn);
        return {fr, ng, s, ap[2], tex, ap[1:0], c, b, 1'b1, xn};
    endfunction
    function automatic logic [31:0] mk_large(input logic [15:0] fr, input logic xn, input logic [2:0] tex,
        input logic ng, input logic s, input logic [2:0] ap, input logic c, input logic b);
        return {fr, xn, tex, ng, s, ap[2], 3'b000, ap[1:0], c, b, 2'b01};
    endfunction

    // ---------------- monitor ----------------
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst && (done || fault)) begin
            if (sbq.size() == 0) begin
                check(0, "R10", "unexpected completion pulse", 32'(done), 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(fault == e.is_f && done == !e.is_f, e.rq, "fault vs done", 32'(fault), 32'(e.is_f));
                check(rd_cnt == e.nreads, "R9", "read count", rd_cnt, e.nreads);
                if (e.nreads >= 1) check(rd_addr[0] == e.a1, "R1", "level-1 address", rd_addr[0], e.a1);
                if (e.nreads >= 2) check(rd_addr[1] == e.a2, "R4", "level-2 address", rd_addr[1], e.a2);
                if (e.is_f) begin
                    check(flt_code == e.code, e.rq, "fault code", 32'(flt_code), 32'(e.code));
                    check(flt_domain == e.fdom, e.rq, "fault domain", 32'(flt_domain), 32'(e.fdom));
                    check(flt_prefetch == e.pf, "R8", "prefetch flag", 32'(flt_prefetch), 32'(e.pf));
                    check(flt_write == (e.wr && !e.pf), "R8", "write flag", 32'(flt_write), 32'(e.wr));
                end else begin
                    check(ent_pa_base == e.pa, e.rq, "pa base", ent_pa_base, e.pa);
                    check(ent_vpn == e.vpn, e.rq, "vpn", 32'(ent_vpn), 32'(e.vpn));
                    check(ent_size == e.sz, e.rq, "size", 32'(ent_size), 32'(e.sz));
                    check(ent_ap == e.ap, e.rq, "ap", 32'(ent_ap), 32'(e.ap));
                    check(ent_domain == e.dom, e.rq, "domain", 32'(ent_domain), 32'(e.dom));
                    check(ent_global == e.g, e.rq, "global", 32'(ent_global), 32'(e.g));
                    check(ent_xn == e.xn, e.rq, "xn", 32'(ent_xn), 32'(e.xn));
                    check(ent_tex == e.tex, e.rq, "tex", 32'(ent_tex), 32'(e.tex));
                    check({ent_c, ent_b, ent_shared} == {e.c, e.b, e.s}, e.rq, "c/b/s",
                          32'({ent_c, ent_b, ent_shared}), 32'({e.c, e.b, e.s}));
                    check(ent_ctx == e.ctx, "R3", "context", 32'(ent_ctx), 32'(e.ctx));
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic [7:0] ctx,
                        input logic [2:0] split, input logic afe, input string rq, input bit poke);
        sbq.push_back(model(va, kind, ctx, split, afe, rq));
        @(negedge clk);
        rd_cnt = 0;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_ctx = ctx;
        req_split = split; req_afe = afe;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'h1);
        if (poke) begin
            req_valid = 1'b1; req_vaddr = 32'hFFF0_0000; req_kind = 2'd2; req_ctx = 8'hEE;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!(done || fault)) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R10", "busy released", 32'(busy), 32'h0);
        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R10", "scoreboard drained", sbq.size(), 0);
    endtask

    initial begin
        mem[32'h0010_048C] = mk_sec(12'hABC, 1, 1, 3'b011, 3'b101, 4'h9, 1, 1, 0, 0);
        mem[32'h0010_00D0] = mk_sec(12'h456, 0, 0, 3'b101, 3'b010, 4'h3, 0, 0, 1, 0);
        mem[32'h0020_21D8] = mk_sec(12'hF0F, 1, 0, 3'b111, 3'b001, 4'hC, 1, 0, 1, 0);
        mem[32'h0010_0048] = mk_sec(12'h321, 0, 1, 3'b001, 3'b110, 4'h6, 0, 1, 1, 0);
        mem[32'h0010_0018] = 32'h1234_5673;
        mem[32'h0010_001C] = mk_sec(12'h111, 0, 0, 3'b011, 3'b000, 4'h2, 0, 0, 0, 1);
        mem[32'h0010_0020] = mk_ptr(22'h000C00, 4'h5);
        mem[32'h0030_000C] = mk_small(20'hBEEF1, 1, 0, 3'b111, 3'b011, 1, 0, 1);
        mem[32'h0030_0040] = mk_large(16'hCAFE, 1, 3'b100, 0, 1, 3'b001, 0, 1);
        mem[32'h0030_00C0] = mk_small(20'h12345, 0, 1, 3'b010, 3'b000, 0, 0, 0);
        mem[32'h0010_0024] = mk_sec(12'h777, 0, 0, 3'b010, 3'b000, 4'hA, 0, 0, 0, 0);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!busy && !done && !fault && !mem_req_valid, "R10", "reset state",
              32'({busy, done, fault, mem_req_valid}), 32'h0);

        walk(32'h1234_5678, 2'd0, 8'h11, 3'd0, 0, "R3", 0);
        walk(32'h0345_6000, 2'd0, 8'h22, 3'd2, 0, "R1", 0);
        walk(32'h8765_4321, 2'd1, 8'h33, 3'd2, 0, "R1", 0);
        walk(32'h0123_4567, 2'd0, 8'h44, 3'd7, 0, "R1", 0);
        walk(32'h0050_0000, 2'd1, 8'h55, 3'd0, 0, "R2", 0);
        walk(32'h0060_0000, 2'd2, 8'h66, 3'd0, 0, "R8", 0);
        walk(32'h0070_0000, 2'd0, 8'h77, 3'd0, 0, "R2", 0);
        walk(32'h0080_3ABC, 2'd0, 8'h88, 3'd0, 0, "R6", 0);
        walk(32'h0081_0123, 2'd2, 8'h99, 3'd0, 0, "R6", 0);
        walk(32'h0082_0000, 2'd1, 8'hAA, 3'd0, 0, "R5", 0);
        walk(32'h0090_0000, 2'd1, 8'hBB, 3'd0, 1, "R7", 0);
        walk(32'h0083_0000, 2'd2, 8'hCC, 3'd0, 1, "R7", 0);
        walk(32'h1234_5678, 2'd0, 8'hDD, 3'd0, 1, "R7", 0);
        bad_en = 1'b1; bad_addr = 32'h0010_048C;
        walk(32'h1234_5678, 2'd1, 8'h01, 3'd0, 0, "R9", 0);
        bad_addr = 32'h0030_000C;
        walk(32'h0080_3ABC, 2'd0, 8'h02, 3'd0, 0, "R9", 0);
        bad_en = 1'b0;
        walk(32'h1234_5678, 2'd0, 8'h03, 3'd0, 0, "R10", 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule